// File: doc/BRIEF.md
# Sequential Integer Divider

This block divides one integer by another over many clock cycles using restoring long division, settling one quotient bit per clock. A one-cycle start pulse captures the dividend, the divisor and a mode select that picks unsigned or two's-complement operands. When the result is ready, the block raises a one-cycle done pulse together with the quotient and the remainder.

In signed mode the block divides the magnitudes of the operands and then fixes the signs in one extra cycle. The quotient is rounded toward zero. A zero divisor and the single signed overflow case (most negative value divided by minus one) each give a fixed, defined answer. Neither case raises a flag or a trap.

The controller has three states. `ST_IDLE` waits for start. `ST_RUN` performs the iterations. `ST_FIX` applies the sign correction and publishes the result. The transitions are:
- `ST_IDLE` to `ST_RUN` on an accepted start.
- `ST_RUN` to `ST_RUN` while iterations remain.
- `ST_RUN` to `ST_FIX` after the last iteration.
- `ST_FIX` to `ST_IDLE` unconditionally.

Top module: `seq_divider`

## Requirements
- R1: After reset, `done_o` is 0 and `quotient_o` and `remainder_o` are all zeros.
- R2: With `signed_i`=0 and a nonzero divisor, `quotient_o` and `remainder_o` are the unsigned floor quotient and remainder: dividend = quotient*divisor + remainder, with remainder < divisor.
- R3: With `signed_i`=1 and a nonzero divisor, the operands are two's complement. The quotient is truncated toward zero and is negative when the operand signs differ. The remainder is zero or carries the sign of the dividend.
- R4: A zero divisor in either mode gives an all-ones `quotient_o` and a `remainder_o` equal to the raw dividend. No other indication is given.
- R5: In signed mode, the most negative dividend divided by -1 gives a quotient equal to the most negative value (the wrapped result) and a remainder of 0. No other indication is given.
- R6: `done_o` is high for exactly one cycle. It rises WIDTH+1 clock edges after the edge that accepted the start: WIDTH iteration cycles plus one sign-correction cycle.
- R7: A start that arrives while the block is in `ST_RUN` or `ST_FIX` is ignored. The running division completes with its own operands, and no extra done pulse follows.
- R8: `quotient_o` and `remainder_o` change only at the edge where `done_o` rises. They hold their values otherwise.
- R9: A start applied in the cycle where `done_o` is high is accepted. The next result follows WIDTH+1 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; operands are sampled with it |
| signed_i | input | 1 | 1 selects two's-complement operands, 0 selects unsigned |
| dividend_i | input | WIDTH | Dividend |
| divisor_i | input | WIDTH | Divisor |
| done_o | output | 1 | One-cycle pulse marking a new result |
| quotient_o | output | WIDTH | Quotient |
| remainder_o | output | WIDTH | Remainder |

## Verification
Two functions can fall in the same cycle: publishing a finished result in `ST_FIX` or on the done cycle, and capturing a new start. The bench provokes this in two ways. It drives start in the exact cycle it sees `done_o` high, which must be accepted. It also drives a second start a few cycles into a running division, which must be ignored. A behavioural model tracks when the block is busy purely from edge counts and checks `done_o`, `quotient_o` and `remainder_o` every clock. Any wrongly accepted or wrongly dropped start therefore shows up as a shifted done pulse or a wrong result.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;
endpackage

// File: rtl/div_prep.sv
// Operand conditioning: magnitudes, result signs and zero-divisor detect.
module div_prep #(
    parameter int W = 32
) (
    input  logic         signed_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] mag_dvd_o,
    output logic [W-1:0] mag_dsr_o,
    output logic         neg_quo_o,
    output logic         neg_rem_o,
    output logic         dsr_zero_o
);
    logic dvd_neg, dsr_neg;

    always_comb begin
        dvd_neg    = signed_i & dividend_i[W-1];
        dsr_neg    = signed_i & divisor_i[W-1];
        mag_dvd_o  = dvd_neg ? (~dividend_i + 1'b1) : dividend_i;
        mag_dsr_o  = dsr_neg ? (~divisor_i + 1'b1) : divisor_i;
        neg_quo_o  = dvd_neg ^ dsr_neg;
        neg_rem_o  = dvd_neg;
        dsr_zero_o = (divisor_i == '0);
    end
endmodule

// File: rtl/div_step.sv
// One restoring iteration: shift in a dividend bit, trial-subtract, restore on borrow.
module div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dsr_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] shifted;
    logic [W:0] trial;
    logic       qbit;

    always_comb begin
        shifted = {rem_i, quo_i[W-1]};
        trial   = shifted - {1'b0, dsr_i};
        qbit    = ~trial[W];
        rem_o   = qbit ? trial[W-1:0] : shifted[W-1:0];
        quo_o   = {quo_i[W-2:0], qbit};
    end
endmodule

// File: rtl/div_fix.sv
// Sign correction and defined results for a zero divisor.
module div_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_mag_i,
    input  logic [W-1:0] rem_mag_i,
    input  logic [W-1:0] dvd_raw_i,
    input  logic         neg_quo_i,
    input  logic         neg_rem_i,
    input  logic         dsr_zero_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    always_comb begin
        if (dsr_zero_i) begin
            quo_o = '1;
            rem_o = dvd_raw_i;
        end else begin
            quo_o = neg_quo_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
            rem_o = neg_rem_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
        end
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import div_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             done_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_ITER = CW'(WIDTH - 1);

    div_state_e state_q, state_d;

    logic [CW-1:0]    iter_q;
    logic [WIDTH-1:0] rem_q, quo_q, dsr_q, dvd_raw_q;
    logic             neg_quo_q, neg_rem_q, zero_q;

    logic [WIDTH-1:0] mag_dvd, mag_dsr;
    logic             neg_quo, neg_rem, dsr_zero;
    logic [WIDTH-1:0] rem_nx, quo_nx;
    logic [WIDTH-1:0] fix_quo, fix_rem;

    div_prep #(.W(WIDTH)) u_prep (
        .signed_i   (signed_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .mag_dvd_o  (mag_dvd),
        .mag_dsr_o  (mag_dsr),
        .neg_quo_o  (neg_quo),
        .neg_rem_o  (neg_rem),
        .dsr_zero_o (dsr_zero)
    );

    div_step #(.W(WIDTH)) u_step (
        .rem_i (rem_q),
        .quo_i (quo_q),
        .dsr_i (dsr_q),
        .rem_o (rem_nx),
        .quo_o (quo_nx)
    );

    div_fix #(.W(WIDTH)) u_fix (
        .quo_mag_i  (quo_q),
        .rem_mag_i  (rem_q),
        .dvd_raw_i  (dvd_raw_q),
        .neg_quo_i  (neg_quo_q),
        .neg_rem_i  (neg_rem_q),
        .dsr_zero_i (zero_q),
        .quo_o      (fix_quo),
        .rem_o      (fix_rem)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)              state_d = ST_RUN;
            ST_RUN:  if (iter_q == LAST_ITER)  state_d = ST_FIX;
            ST_FIX:                            state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // Iteration datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_q    <= '0;
            rem_q     <= '0;
            quo_q     <= '0;
            dsr_q     <= '0;
            dvd_raw_q <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            zero_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        iter_q    <= '0;
                        rem_q     <= '0;
                        quo_q     <= mag_dvd;
                        dsr_q     <= mag_dsr;
                        dvd_raw_q <= dividend_i;
                        neg_quo_q <= neg_quo;
                        neg_rem_q <= neg_rem;
                        zero_q    <= dsr_zero;
                    end
                end
                ST_RUN: begin
                    rem_q  <= rem_nx;
                    quo_q  <= quo_nx;
                    iter_q <= iter_q + 1'b1;
                end
                ST_FIX: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            quotient_o  <= '0;
            remainder_o <= '0;
        end else begin
            done_o <= (state_q == ST_FIX);
            if (state_q == ST_FIX) begin
                quotient_o  <= fix_quo;
                remainder_o <= fix_rem;
            end
        end
    end
endmodule

// File: rtl/div_checker.sv
module div_checker
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         signed_i,
    input logic [W-1:0] dividend_i,
    input logic [W-1:0] divisor_i,
    input logic         done_o,
    input logic [W-1:0] quotient_o,
    input logic [W-1:0] remainder_o,
    input div_state_e   state_i
);
    logic         accept;
    logic [31:0]  since;
    logic         running;
    logic [W-1:0] cap_dvd, cap_dsr;
    logic         cap_sgn;
    logic [2*W-1:0] recon;

    assign accept = (state_i == ST_IDLE) && start_i;
    assign recon  = {{W{1'b0}}, quotient_o} * {{W{1'b0}}, cap_dsr}
                  + {{W{1'b0}}, remainder_o};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since   <= '0;
            running <= 1'b0;
            cap_dvd <= '0;
            cap_dsr <= '0;
            cap_sgn <= 1'b0;
        end else if (accept) begin
            since   <= '0;
            running <= 1'b1;
            cap_dvd <= dividend_i;
            cap_dsr <= divisor_i;
            cap_sgn <= signed_i;
        end else if (running) begin
            since <= since + 1;
            if (done_o) running <= 1'b0;
        end
    end

    // R6: single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6 / R7: done lands exactly WIDTH+1 edges after the accepted start
    p_done_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (running && since == 32'(W + 1)));

    // R8: results hold between done pulses
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quotient_o) && $stable(remainder_o)));

    // R4: zero divisor gives all ones and the dividend
    p_div_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_dsr == '0) |-> (quotient_o == '1 && remainder_o == cap_dvd));

    // R2: unsigned identity
    p_unsigned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cap_sgn && cap_dsr != '0) |->
            (recon == {{W{1'b0}}, cap_dvd} && remainder_o < cap_dsr));

    // R3: signed remainder follows dividend sign
    p_rem_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_sgn && cap_dsr != '0 && remainder_o != '0) |->
            (remainder_o[W-1] == cap_dvd[W-1]));
endmodule

bind seq_divider div_checker #(.W(WIDTH)) u_div_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .signed_i    (signed_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .done_o      (done_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .state_i     (state_q)
);

// File: tb/test_seq_divider.sv
`timescale 1ns/1ps
module test_seq_divider;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_r = 1'b0;
    logic         sgn_r = 1'b0;
    logic [W-1:0] a_r = '0;
    logic [W-1:0] b_r = '0;
    logic         done_o;
    logic [W-1:0] quotient_o, remainder_o;

    always #2 clk = ~clk;

    seq_divider #(.WIDTH(W)) i_seq_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_r),
        .signed_i    (sgn_r),
        .dividend_i  (a_r),
        .divisor_i   (b_r),
        .done_o      (done_o),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o)
    );

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference
    task automatic ref_div(input bit sgn, input logic [W-1:0] a, input logic [W-1:0] b,
                           output logic [W-1:0] q, output logic [W-1:0] r);
        longint sa, sb, qq, rr;
        if (b == '0) begin
            q = '1;
            r = a;
        end else begin
            if (sgn) begin
                sa = $signed(a);
                sb = $signed(b);
            end else begin
                sa = 0; sa[W-1:0] = a;
                sb = 0; sb[W-1:0] = b;
            end
            qq = sa / sb;
            rr = sa % sb;
            q = qq[W-1:0];
            r = rr[W-1:0];
        end
    endtask

    int           n_edge = 0;
    bit           active = 1'b0;
    int           due = 0;
    logic [W-1:0] pend_q = '0, pend_r = '0, hold_q = '0, hold_r = '0;
    string        pend_tag = "R2";

    always @(posedge clk) begin
        if (rst_n) begin
            if (start_r) begin
                if (!active || n_edge >= due) begin
                    ref_div(sgn_r, a_r, b_r, pend_q, pend_r);
                    if (b_r == '0)                                  pend_tag = "R4";
                    else if (sgn_r && a_r == {1'b1, {(W-1){1'b0}}} && b_r == '1)
                                                                     pend_tag = "R5";
                    else if (sgn_r)                                 pend_tag = "R3";
                    else                                            pend_tag = "R2";
                    if (active && n_edge == due) pend_tag = {pend_tag, "/R9"};
                    active = 1'b1;
                    due    = n_edge + 1 + W + 1;
                end else begin
                    pend_tag = {pend_tag, "/R7"};
                end
            end
            n_edge = n_edge + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit    exp_done;
            string tag;
            exp_done = active && (n_edge == due);
            chk(done_o == exp_done, "R6 done", 64'(done_o), 64'(exp_done));
            if (exp_done) begin
                hold_q = pend_q;
                hold_r = pend_r;
                tag    = pend_tag;
            end else begin
                tag = "R8";
            end
            chk(quotient_o == hold_q, {tag, " quotient"}, 64'(quotient_o), 64'(hold_q));
            chk(remainder_o == hold_r, {tag, " remainder"}, 64'(remainder_o), 64'(hold_r));
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=%0d expected<150000", wd);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    task automatic issue(input bit sgn, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        start_r = 1'b1; sgn_r = sgn; a_r = a; b_r = b;
        @(negedge clk);
        start_r = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done_o && guard < 200) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic run_op(input bit sgn, input logic [W-1:0] a, input logic [W-1:0] b);
        issue(sgn, a, b);
        wait_done();
        @(negedge clk);
    endtask

    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(done_o == 1'b0, "R1 done", 64'(done_o), 64'd0);
        chk(quotient_o == '0, "R1 quotient", 64'(quotient_o), 64'd0);
        chk(remainder_o == '0, "R1 remainder", 64'(remainder_o), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: unsigned
        run_op(1'b0, 32'd100, 32'd7);
        run_op(1'b0, 32'hFFFF_FFFF, 32'd1);
        run_op(1'b0, 32'd5, 32'd9);
        run_op(1'b0, 32'd0, 32'd3);
        run_op(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op(1'b0, 32'h8000_0000, 32'd2);
        run_op(1'b0, 32'hFFFF_FFF9, 32'd2); // large unsigned, not negative

        // R3: signed sign combinations
        run_op(1'b1, -32'sd7, 32'sd2);
        run_op(1'b1, 32'sd7, -32'sd2);
        run_op(1'b1, -32'sd7, -32'sd2);
        run_op(1'b1, 32'sd7, 32'sd2);
        run_op(1'b1, MINV, 32'd1);
        run_op(1'b1, -32'sd1, MINV);

        // R5: overflow case
        run_op(1'b1, MINV, '1);

        // R4: zero divisor both modes
        run_op(1'b0, 32'd1234, 32'd0);
        run_op(1'b1, -32'sd5, 32'd0);

        // R7: start while busy is ignored
        issue(1'b0, 32'd1000, 32'd10);
        repeat (5) @(negedge clk);
        issue(1'b1, -32'sd77, 32'd3);
        wait_done();
        repeat (W + 6) @(negedge clk);

        // R9: start in the done cycle is accepted
        issue(1'b0, 32'd999, 32'd4);
        wait_done();
        start_r = 1'b1; sgn_r = 1'b1; a_r = -32'sd999; b_r = 32'd4;
        @(negedge clk);
        start_r = 1'b0;
        wait_done();
        @(negedge clk);

        // Mixed patterns
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] a, b;
            a = $urandom;
            b = (i % 4 == 0) ? (32'($urandom) >> (i % 29)) : 32'($urandom);
            run_op(1'(i % 2), a, b);
        end

        repeat (W + 4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule